// File: doc/BRIEF.md
# Widening Vector Multiply-Accumulate Unit

This unit decodes and executes one 32-bit vector instruction. The instruction multiplies narrow integer lanes taken from two 64-bit sources. Each product is formed at double width and then added to, or subtracted from, the matching lane of a 128-bit accumulator. The caller supplies the instruction word with a valid strobe, both 64-bit source values and the current 128-bit destination value.

The unit returns three things. The first is the combinational field decode: a pattern-match flag, an undefined-instruction flag and three 5-bit register indices. The second is the registered 128-bit result, and the third is a one-cycle result-valid strobe. The register file, hazard handling and any saturating or floating-point forms are left to the surrounding pipeline.

Top module: `wmac_unit`

## Requirements
- R1: An instruction matches only when `(instr & 32'hFE80_0D50) == 32'hF280_0800`, which fixes bits 31:25=1111001, 23=1, 11:10=10, 8=0, 6=0 and 4=0. A word that does not match drives `dec_match` low and `dec_undef` low and produces no result.
- R2: A matching word whose size field (bits 21:20) is 3 raises `dec_undef`, and no result is produced.
- R3: A matching word with an odd destination field (bit 12 set) raises `dec_undef`, and no result is produced.
- R4: For a matching word, `dst_idx` = {bit 22, bits 15:12}, `srca_idx` = {bit 7, bits 19:16} and `srcb_idx` = {bit 5, bits 3:0}.
- R5: Size field s gives a source element width E = 8<<s (8, 16 or 32). Source lane i is bits [(i+1)E-1:iE] of each source, and it maps to bits [(i+1)2E-1:i·2E] of the accumulator and of the result.
- R6: Bit 24 set zero-extends each source element to 2E bits before the multiply. Bit 24 clear sign-extends it.
- R7: Bit 9 clear adds each product to its accumulator lane. Bit 9 set subtracts the product from that lane.
- R8: Every lane add and subtract wraps modulo 2^(2E), and no carry or borrow passes between lanes.
- R9: A cycle with `instr_valid` high and a matching, defined word gives `res_valid` high for exactly the next cycle, with the result on `res_data`. In every other case `res_valid` stays low and `res_data` keeps its previous value.
- R10: While reset is active, and after reset, `res_valid` is low and `res_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| src_a | input | 64 | First doubleword source |
| src_b | input | 64 | Second doubleword source |
| acc_in | input | 128 | Current destination quadword value |
| dec_match | output | 1 | Word matches the fixed bits of the encoding |
| dec_undef | output | 1 | Matching word is undefined (size 3 or odd destination) |
| dst_idx | output | 5 | Destination register index |
| srca_idx | output | 5 | First source register index |
| srcb_idx | output | 5 | Second source register index |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 128 | Accumulated result |

## Verification
The hardest case to reach is wrap-around at a lane boundary. It only shows when an accumulator lane sits at its top or bottom value and the product has the right sign and size to cross it, and the result must then prove that no carry leaked into the neighbouring lane. The stimulus builds these cases directly: it pairs all-ones and minimum-negative sources with accumulators whose lanes hold all-ones or zero, for every size and both operations. Seeded pseudo-random words are added on top, checked against a lane-by-lane reference model.

// File: rtl/wmac_pkg.sv
package wmac_pkg;
  localparam logic [31:0] ENC_MASK  = 32'hFE80_0D50;
  localparam logic [31:0] ENC_MATCH = 32'hF280_0800;
  localparam int          SRC_W     = 64;
  localparam int          ACC_W     = 2 * SRC_W;
  localparam int          NUM_SZ    = 3;
  localparam int          IDX_W     = 5;

  typedef struct packed {
    logic             match;
    logic             undef;
    logic [1:0]       size;
    logic             uns;
    logic             sub;
    logic [IDX_W-1:0] dst;
    logic [IDX_W-1:0] srca;
    logic [IDX_W-1:0] srcb;
  } dec_t;
endpackage

// File: rtl/wmac_rst_sync.sv
module wmac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/wmac_decode.sv
module wmac_decode
  import wmac_pkg::*;
(
  input  logic [31:0] instr,
  output dec_t        dec
);
  logic hit;
  logic bad_size;
  logic odd_dst;

  always_comb begin
    hit      = (instr & ENC_MASK) == ENC_MATCH;
    bad_size = instr[21:20] == 2'b11;
    odd_dst  = instr[12];
    dec.match = hit;
    dec.undef = hit & (bad_size | odd_dst);
    dec.size  = instr[21:20];
    dec.uns   = instr[24];
    dec.sub   = instr[9];
    dec.dst   = {instr[22], instr[15:12]};
    dec.srca  = {instr[7],  instr[19:16]};
    dec.srcb  = {instr[5],  instr[3:0]};
  end
endmodule

// File: rtl/wmac_lane.sv
module wmac_lane #(
  parameter int EW = 8
) (
  input  logic [EW-1:0]   a,
  input  logic [EW-1:0]   b,
  input  logic [2*EW-1:0] acc,
  input  logic            uns,
  input  logic            sub,
  output logic [2*EW-1:0] res
);
  logic [2*EW-1:0] ext_a;
  logic [2*EW-1:0] ext_b;
  logic [2*EW-1:0] prod;

  always_comb begin
    ext_a = {{EW{~uns & a[EW-1]}}, a};
    ext_b = {{EW{~uns & b[EW-1]}}, b};
    prod  = ext_a * ext_b;
    res   = sub ? (acc - prod) : (acc + prod);
  end
endmodule

// File: rtl/wmac_datapath.sv
module wmac_datapath
  import wmac_pkg::*;
(
  input  logic [SRC_W-1:0] src_a,
  input  logic [SRC_W-1:0] src_b,
  input  logic [ACC_W-1:0] acc_in,
  input  logic [1:0]       size,
  input  logic             uns,
  input  logic             sub,
  output logic [ACC_W-1:0] res
);
  logic [NUM_SZ-1:0][ACC_W-1:0] res_by_size;

  for (genvar s = 0; s < NUM_SZ; s++) begin : g_size
    localparam int EW = 8 << s;
    localparam int NL = SRC_W / EW;
    logic [ACC_W-1:0] lanes;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      wmac_lane #(.EW(EW)) u_lane (
        .a   (src_a[l*EW +: EW]),
        .b   (src_b[l*EW +: EW]),
        .acc (acc_in[l*2*EW +: 2*EW]),
        .uns (uns),
        .sub (sub),
        .res (lanes[l*2*EW +: 2*EW])
      );
    end
    assign res_by_size[s] = lanes;
  end

  always_comb begin
    res = '0;
    for (int s = 0; s < NUM_SZ; s++) begin
      if (size == s[1:0]) res = res_by_size[s];
    end
  end
endmodule

// File: rtl/wmac_unit.sv
module wmac_unit
  import wmac_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                instr_valid,
  input  logic [31:0]         instr,
  input  logic [SRC_W-1:0]    src_a,
  input  logic [SRC_W-1:0]    src_b,
  input  logic [ACC_W-1:0]    acc_in,
  output logic                dec_match,
  output logic                dec_undef,
  output logic [IDX_W-1:0]    dst_idx,
  output logic [IDX_W-1:0]    srca_idx,
  output logic [IDX_W-1:0]    srcb_idx,
  output logic                res_valid,
  output logic [ACC_W-1:0]    res_data
);
  logic             rst_sync_n;
  dec_t             dec;
  logic [ACC_W-1:0] dp_res;
  logic             fire;
  logic             vld_d, vld_q;
  logic [ACC_W-1:0] res_d, res_q;
  logic             res_en;

  wmac_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wmac_decode u_decode (
    .instr (instr),
    .dec   (dec)
  );

  wmac_datapath u_datapath (
    .src_a  (src_a),
    .src_b  (src_b),
    .acc_in (acc_in),
    .size   (dec.size),
    .uns    (dec.uns),
    .sub    (dec.sub),
    .res    (dp_res)
  );

  // next-state logic
  always_comb begin
    fire   = instr_valid & dec.match & ~dec.undef;
    vld_d  = fire;
    res_en = fire;
    res_d  = dp_res;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (res_en) res_q <= res_d;
    end
  end

  assign dec_match = dec.match;
  assign dec_undef = dec.undef;
  assign dst_idx   = dec.dst;
  assign srca_idx  = dec.srca;
  assign srcb_idx  = dec.srcb;
  assign res_valid = vld_q;
  assign res_data  = res_q;
endmodule

// File: rtl/wmac_unit_chk.sv
module wmac_unit_chk (
  input logic         clk,
  input logic         rst_ni,
  input logic         instr_valid,
  input logic [31:0]  instr,
  input logic [63:0]  src_a,
  input logic [63:0]  src_b,
  input logic [127:0] acc_in,
  input logic         dec_match,
  input logic         dec_undef,
  input logic         res_valid,
  input logic [127:0] res_data
);
  logic fire;
  assign fire = instr_valid & dec_match & ~dec_undef;

  // R9
  fire_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    fire |=> res_valid);

  // R9
  idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !fire |=> !res_valid);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !fire |=> $stable(res_data));

  // R1
  undef_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    dec_undef |-> dec_match);

  // R2
  size3_undef_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (dec_match && instr[21:20] == 2'b11) |-> dec_undef);

  // R3
  odd_dst_undef_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (dec_match && instr[12]) |-> dec_undef);

  // R6
  byte_lane0_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (fire && instr[21:20] == 2'b00 && instr[24] && !instr[9]) |=>
      res_data[15:0] == 16'($past(acc_in[15:0]) +
                            16'($past(src_a[7:0])) * 16'($past(src_b[7:0]))));

  // R10
  always @(posedge clk) begin
    if (!rst_ni) begin
      reset_clear_chk: assert (!res_valid && res_data == '0);
    end
  end
endmodule

bind wmac_unit wmac_unit_chk u_chk (
  .clk         (clk),
  .rst_ni      (rst_sync_n),
  .instr_valid (instr_valid),
  .instr       (instr),
  .src_a       (src_a),
  .src_b       (src_b),
  .acc_in      (acc_in),
  .dec_match   (dec_match),
  .dec_undef   (dec_undef),
  .res_valid   (res_valid),
  .res_data    (res_data)
);

// File: tb/wmac_unit_tb.sv
module wmac_unit_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         instr_valid;
  logic [31:0]  instr;
  logic [63:0]  src_a, src_b;
  logic [127:0] acc_in;
  logic         dec_match, dec_undef;
  logic [4:0]   dst_idx, srca_idx, srcb_idx;
  logic         res_valid;
  logic [127:0] res_data;

  int n_checks = 0;
  int n_fail   = 0;
  logic [127:0] last_exp = '0;
  logic [63:0]  rng = 64'h9E37_79B9_7F4A_7C15;

  typedef struct {
    bit           v;
    logic [127:0] d;
    string        tag;
  } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;

  wmac_unit u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
    .dec_match(dec_match), .dec_undef(dec_undef),
    .dst_idx(dst_idx), .srca_idx(srca_idx), .srcb_idx(srcb_idx),
    .res_valid(res_valid), .res_data(res_data)
  );

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(bit u, bit d, logic [1:0] sz, logic [3:0] vn,
                                      logic [3:0] vd, bit op, bit n, bit m, logic [3:0] vm);
    return {7'b1111001, u, 1'b1, d, sz, vn, vd, 2'b10, op, 1'b0, n, 1'b0, m, 1'b0, vm};
  endfunction

  function automatic logic [127:0] ref_mac(logic [1:0] sz, bit u, bit op,
                                           logic [63:0] a, logic [63:0] b, logic [127:0] acc);
    int ew = 8 << sz;
    int nl = 64 / ew;
    logic [127:0] r = '0;
    for (int l = 0; l < nl; l++) begin
      logic [127:0] m, lo, ea, eb, pr, la;
      m  = (128'd1 << (2 * ew)) - 1;
      lo = (128'd1 << ew) - 1;
      ea = (128'(a) >> (l * ew)) & lo;
      eb = (128'(b) >> (l * ew)) & lo;
      if (!u && ea[ew-1]) ea = ea | ~lo;
      if (!u && eb[ew-1]) eb = eb | ~lo;
      pr = (ea * eb) & m;
      la = (acc >> (l * 2 * ew)) & m;
      la = op ? ((la - pr) & m) : ((la + pr) & m);
      r  = r | (la << (l * 2 * ew));
    end
    return r;
  endfunction

  function automatic logic [63:0] rnd64();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 7);
    rng = rng ^ (rng << 17);
    return rng;
  endfunction

  // driver: checks decode, pushes the expected output of the next cycle
  task automatic issue(bit v, logic [31:0] w, logic [63:0] a, logic [63:0] b,
                       logic [127:0] acc, string tag);
    bit em, eu, fire;
    item_t it;
    @(negedge clk);
    instr_valid = v; instr = w; src_a = a; src_b = b; acc_in = acc;
    #1;
    em = (w & 32'hFE80_0D50) == 32'hF280_0800;
    eu = em && (w[21:20] == 2'b11 || w[12]);
    check(dec_match === em, {tag, " R1 match"}, 128'(dec_match), 128'(em));
    check(dec_undef === eu, {tag, " R2/R3 undef"}, 128'(dec_undef), 128'(eu));
    if (em) begin
      check(dst_idx === {w[22], w[15:12]}, {tag, " R4 dst"}, 128'(dst_idx), 128'({w[22], w[15:12]}));
      check(srca_idx === {w[7], w[19:16]}, {tag, " R4 srca"}, 128'(srca_idx), 128'({w[7], w[19:16]}));
      check(srcb_idx === {w[5], w[3:0]}, {tag, " R4 srcb"}, 128'(srcb_idx), 128'({w[5], w[3:0]}));
    end
    fire = v && em && !eu;
    if (fire) last_exp = ref_mac(w[21:20], w[24], w[9], a, b, acc);
    it.v = fire; it.d = last_exp; it.tag = tag;
    @(posedge clk);
    sb_q.push_back(it);
  endtask

  task automatic idle();
    issue(1'b0, 32'h0, '0, '0, '0, "idle");
  endtask

  // monitor: compares the design output against the scoreboard
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(res_valid === it.v, {it.tag, " R9 valid"}, 128'(res_valid), 128'(it.v));
      check(res_data === it.d, {it.tag, " R5/R6/R7/R8 data"}, res_data, it.d);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    instr_valid = 1'b0; instr = '0; src_a = '0; src_b = '0; acc_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    check(res_valid === 1'b0, "R10 valid in reset", 128'(res_valid), 128'(0));
    check(res_data === '0, "R10 data in reset", res_data, '0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(res_valid === 1'b0, "R10 valid after reset", 128'(res_valid), 128'(0));

    // R5 R6 R7 R8 corner cases, every size, signedness and operation
    for (int sz = 0; sz < 3; sz++) begin
      for (int u = 0; u < 2; u++) begin
        for (int op = 0; op < 2; op++) begin
          issue(1'b1, enc(u[0], 1'b0, sz[1:0], 4'h1, 4'h2, op[0], 1'b0, 1'b0, 4'h3),
                '1, '1, '1, "R8 ones");
          issue(1'b1, enc(u[0], 1'b1, sz[1:0], 4'h4, 4'hE, op[0], 1'b1, 1'b1, 4'h5),
                64'h8080_8000_8000_0000, 64'h7F80_FF80_7FFF_FFFF, '0, "R6 minneg");
          issue(1'b1, enc(u[0], 1'b0, sz[1:0], 4'h7, 4'h6, op[0], 1'b1, 1'b0, 4'h9),
                64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210,
                128'hFFFF_0000_FFFF_0000_0000_FFFF_0000_FFFF, "R5 lanes");
        end
      end
    end

    // R1 mismatched fixed bits, valid high
    issue(1'b1, enc(1'b0, 1'b0, 2'd0, 4'h1, 4'h2, 1'b0, 1'b0, 1'b0, 4'h3) | 32'h10,
          '1, '1, '1, "R1 bit4");
    issue(1'b1, enc(1'b1, 1'b0, 2'd1, 4'h1, 4'h2, 1'b0, 1'b0, 1'b0, 4'h3) & ~32'h0080_0000,
          '1, '1, '1, "R1 bit23");
    issue(1'b1, 32'h0, '1, '1, '1, "R1 zero");
    // R2 size 3
    issue(1'b1, enc(1'b0, 1'b0, 2'd3, 4'h1, 4'h2, 1'b0, 1'b0, 1'b0, 4'h3), '1, '1, '1, "R2 size3");
    // R3 odd destination
    issue(1'b1, enc(1'b1, 1'b1, 2'd1, 4'h1, 4'h3, 1'b1, 1'b0, 1'b0, 4'h3), '1, '1, '1, "R3 odd");
    // R9 defined word with valid low
    issue(1'b0, enc(1'b1, 1'b0, 2'd0, 4'h1, 4'h2, 1'b0, 1'b0, 1'b0, 4'h3), '1, '1, '1, "R9 novalid");
    idle();

    // seeded random words, all sizes
    for (int k = 0; k < 60; k++) begin
      logic [63:0] r0, r1, r2, r3;
      logic [31:0] w;
      r0 = rnd64(); r1 = rnd64(); r2 = rnd64(); r3 = rnd64();
      w = enc(r0[0], r0[1], r0[3:2], r0[7:4], {r0[11:9], 1'b0}, r0[12], r0[13], r0[14], r0[19:16]);
      issue(r0[20] | r0[21], w, r1, r2, {r3, r1 ^ r2}, "R8 random");
    end
    idle();
    idle();

    // R10 reset mid-run clears the held result
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(res_valid === 1'b0, "R10 valid mid reset", 128'(res_valid), 128'(0));
    check(res_data === '0, "R10 data mid reset", res_data, '0);
    @(negedge clk);
    rst_n = 1'b1;
    last_exp = '0;
    repeat (4) @(posedge clk);
    idle();
    issue(1'b1, enc(1'b0, 1'b0, 2'd2, 4'h0, 4'h0, 1'b1, 1'b0, 1'b0, 4'h0),
          64'h0000_0001_FFFF_FFFF, 64'h0000_0002_0000_0001, '0, "R7 sub wrap");
    idle();
    idle();

    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule